// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between a synchronous request port and an external asynchronous static RAM of 32K bytes. A client asks for one byte at a time: it raises a request with an address, a direction flag and, for stores, a data byte. The controller then produces the chip-select, write-strobe and output-enable pin sequence, and drives or samples the shared data lines. Loads come back on a read-data port together with a one-cycle valid pulse.

Every analog timing minimum of the memory is a nanosecond parameter. At elaboration each one becomes a cycle count: the minimum is divided by the clock period parameter and rounded up, and no count is less than one cycle. The address moves only while the chip select and the write strobe are both inactive. The memory's output enable stays inactive for the whole of every store. The controller drives the data lines only inside the write strobe, and never while the memory could still be driving them after a load. While no request is in flight, all three control pins are high and the data lines are released, which leaves the memory in standby.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset and whenever no request is in flight, sramCeN, sramWeN and sramOeN are 1, sramDoutEn is 0, and reqReady is 1.
- R2: sramAddr changes only on a clock edge where sramCeN and sramWeN are 1 both before and after the edge.
- R3: A load (reqWrite=0) holds sramCeN=0, sramOeN=0 and sramWeN=1 for the access count, which is the largest of the address, chip-enable and output-enable access times in cycles. It samples sramDin on the edge that ends that count, and then presents the byte on rdData with rdValid=1 for exactly one cycle.
- R4: A store (reqWrite=1) keeps sramOeN=1 throughout. It holds sramCeN=0 and sramWeN=0 together for at least 50 ns, which covers the 45 ns strobe width and the 50 ns address-valid and chip-enable windows.
- R5: sramDoutEn is 1 only while sramCeN=0 and sramWeN=0, and never in the first cycle of the strobe. Once raised it stays on until the strobe ends, which gives at least 25 ns of data before the strobe ends. It falls in the same cycle that sramWeN rises. The byte written is reqWdata.
- R6: After a load, sramDoutEn stays 0 until at least 20 ns (the output-release time) after sramOeN and sramCeN have returned to 1.
- R7: reqReady falls on the acceptance edge and stays 0 for at least the 55 ns cycle time (11 cycles at 5 ns).
- R8: A request held high while reqReady is 0 is not taken until reqReady returns. It is then taken exactly once, so no request is dropped or duplicated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Controller idle; a request is taken on this edge |
| reqWrite | input | 1 | 1 = store, 0 = load |
| reqAddr | input | 15 | Byte address |
| reqWdata | input | 8 | Store data |
| rdData | output | 8 | Load result |
| rdValid | output | 1 | One-cycle pulse marking rdData |
| sramAddr | output | 15 | Address pins of the memory |
| sramDout | output | 8 | Data driven toward the memory |
| sramDin | input | 8 | Data read from the memory pins |
| sramDoutEn | output | 1 | Enables the data pin drivers |
| sramCeN | output | 1 | Chip select, active low |
| sramWeN | output | 1 | Write strobe, active low |
| sramOeN | output | 1 | Output enable, active low |

## Verification
The bench pairs the controller with a cycle-level memory model. The model returns a poison byte until 55 ns of continuous read selection have passed, so a controller that samples one cycle early returns wrong data. The model times every write strobe, and the window in which the drivers are on inside it, and flags strobes that are too short, drivers that switch on outside the strobe, and address moves while a pin is low. It marks the 20 ns after a load as memory-driven, so a missing turnaround between a load and a following store shows up as bus contention. The bench also queues requests back to back while the controller is busy. A controller that dropped or replayed a held request would leave the scoreboard with missing or extra loads, or memory contents that do not match.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

  // Per-cycle strobes from the sequencer to the pin datapath. They are the
  // values the pins take after the coming clock edge.
  typedef struct packed {
    logic load;     // latch address, direction and write data
    logic capture;  // sample the memory data pins
    logic ceLow;
    logic weLow;
    logic oeLow;
    logic drive;    // enable the data drivers
  } sramStrobes_t;

  // Ceiling of a nanosecond minimum over the clock period, at least one cycle.
  function automatic int nsToCycles(input int ns, input int periodNs);
    int c;
    c = (ns + periodNs - 1) / periodNs;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctrl_seq.sv
`timescale 1ns/1ps
module sram_ctrl_seq
  import sram_ctrl_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 5,
  parameter int T_RC_NS  = 55,
  parameter int T_AA_NS  = 55,
  parameter int T_ACE_NS = 55,
  parameter int T_OE_NS  = 30,
  parameter int T_WC_NS  = 55,
  parameter int T_AW_NS  = 50,
  parameter int T_CW_NS  = 50,
  parameter int T_WP_NS  = 45,
  parameter int T_DW_NS  = 25,
  parameter int T_OHZ_NS = 20,
  parameter int T_CHZ_NS = 20
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         reqWrite,
  output logic         reqReady,
  output sramStrobes_t strobes
);

  localparam int RC_CYC  = nsToCycles(T_RC_NS, CLK_PERIOD_NS);
  localparam int WC_CYC  = nsToCycles(T_WC_NS, CLK_PERIOD_NS);
  localparam int ACC_CYC = maxOf(nsToCycles(T_AA_NS, CLK_PERIOD_NS),
                                 maxOf(nsToCycles(T_ACE_NS, CLK_PERIOD_NS),
                                       nsToCycles(T_OE_NS, CLK_PERIOD_NS)));
  // One leading undriven cycle, then at least the data-setup count driven.
  localparam int STB_CYC = maxOf(maxOf(nsToCycles(T_WP_NS, CLK_PERIOD_NS),
                                       nsToCycles(T_CW_NS, CLK_PERIOD_NS)),
                                 maxOf(nsToCycles(T_AW_NS, CLK_PERIOD_NS),
                                       nsToCycles(T_DW_NS, CLK_PERIOD_NS) + 1));
  localparam int HZ_CYC  = maxOf(nsToCycles(T_OHZ_NS, CLK_PERIOD_NS),
                                 nsToCycles(T_CHZ_NS, CLK_PERIOD_NS));
  localparam int RD_TAIL_CYC = maxOf(RC_CYC - ACC_CYC, 1);
  localparam int WR_TAIL_CYC = maxOf(WC_CYC - STB_CYC, 1);
  localparam int CNT_MAX = maxOf(maxOf(ACC_CYC, STB_CYC),
                                 maxOf(HZ_CYC, maxOf(RD_TAIL_CYC, WR_TAIL_CYC)));
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_TURN, ST_SETUP, ST_RD_ACC, ST_RD_TAIL, ST_WR_STB, ST_WR_TAIL
  } seqState_t;

  seqState_t        state, stateNext;
  logic [CNT_W-1:0] cnt, cntNext;
  logic             isWrite, isWriteNext;
  logic             lastRead, lastReadNext;

  always_comb begin
    stateNext    = state;
    cntNext      = (cnt != '0) ? cnt - 1'b1 : cnt;
    isWriteNext  = isWrite;
    lastReadNext = lastRead;
    strobes      = '0;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strobes.load = 1'b1;
          isWriteNext  = reqWrite;
          if (reqWrite && lastRead) begin
            stateNext = ST_TURN;
            cntNext   = CNT_W'(HZ_CYC - 1);
          end else begin
            stateNext = ST_SETUP;
          end
        end
      end
      ST_TURN: begin
        if (cnt == '0) stateNext = ST_SETUP;
      end
      ST_SETUP: begin
        if (isWrite) begin
          stateNext    = ST_WR_STB;
          cntNext      = CNT_W'(STB_CYC - 1);
          lastReadNext = 1'b0;
        end else begin
          stateNext = ST_RD_ACC;
          cntNext   = CNT_W'(ACC_CYC - 1);
        end
      end
      ST_RD_ACC: begin
        if (cnt == '0) begin
          strobes.capture = 1'b1;
          lastReadNext    = 1'b1;
          stateNext       = ST_RD_TAIL;
          cntNext         = CNT_W'(RD_TAIL_CYC - 1);
        end
      end
      ST_RD_TAIL: begin
        if (cnt == '0) stateNext = ST_IDLE;
      end
      ST_WR_STB: begin
        if (cnt == '0) begin
          stateNext = ST_WR_TAIL;
          cntNext   = CNT_W'(WR_TAIL_CYC - 1);
        end
      end
      ST_WR_TAIL: begin
        if (cnt == '0) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase

    // Pin levels for the next cycle follow the next state.
    strobes.ceLow = (stateNext == ST_RD_ACC) || (stateNext == ST_WR_STB);
    strobes.oeLow = (stateNext == ST_RD_ACC);
    strobes.weLow = (stateNext == ST_WR_STB);
    strobes.drive = (stateNext == ST_WR_STB) && (state == ST_WR_STB);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      isWrite  <= 1'b0;
      lastRead <= 1'b0;
    end else begin
      state    <= stateNext;
      cnt      <= cntNext;
      isWrite  <= isWriteNext;
      lastRead <= lastReadNext;
    end
  end

  assign reqReady = (state == ST_IDLE);

endmodule

// File: rtl/sram_ctrl_datapath.sv
`timescale 1ns/1ps
module sram_ctrl_datapath
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  sramStrobes_t      strobes,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] sramDin,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic [ADDR_W-1:0] sramAddr,
  output logic [DATA_W-1:0] sramDout,
  output logic              sramDoutEn,
  output logic              sramCeN,
  output logic              sramWeN,
  output logic              sramOeN
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
    end else if (strobes.load) begin
      addrQ  <= reqAddr;
      wdataQ <= reqWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sramCeN    <= 1'b1;
      sramWeN    <= 1'b1;
      sramOeN    <= 1'b1;
      sramDoutEn <= 1'b0;
    end else begin
      sramCeN    <= ~strobes.ceLow;
      sramWeN    <= ~strobes.weLow;
      sramOeN    <= ~strobes.oeLow;
      sramDoutEn <= strobes.drive;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= strobes.capture;
      if (strobes.capture) rdData <= sramDin;
    end
  end

  assign sramAddr = addrQ;
  assign sramDout = wdataQ;

endmodule

// File: rtl/sram_async_ctrl.sv
`timescale 1ns/1ps
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8,
  parameter int CLK_PERIOD_NS = 5,
  parameter int T_RC_NS  = 55,
  parameter int T_AA_NS  = 55,
  parameter int T_ACE_NS = 55,
  parameter int T_OE_NS  = 30,
  parameter int T_WC_NS  = 55,
  parameter int T_AW_NS  = 50,
  parameter int T_CW_NS  = 50,
  parameter int T_WP_NS  = 45,
  parameter int T_DW_NS  = 25,
  parameter int T_OHZ_NS = 20,
  parameter int T_CHZ_NS = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic [ADDR_W-1:0] sramAddr,
  output logic [DATA_W-1:0] sramDout,
  input  logic [DATA_W-1:0] sramDin,
  output logic              sramDoutEn,
  output logic              sramCeN,
  output logic              sramWeN,
  output logic              sramOeN
);

  sramStrobes_t strobes;

  sram_ctrl_seq #(
    .CLK_PERIOD_NS(CLK_PERIOD_NS),
    .T_RC_NS(T_RC_NS), .T_AA_NS(T_AA_NS), .T_ACE_NS(T_ACE_NS), .T_OE_NS(T_OE_NS),
    .T_WC_NS(T_WC_NS), .T_AW_NS(T_AW_NS), .T_CW_NS(T_CW_NS), .T_WP_NS(T_WP_NS),
    .T_DW_NS(T_DW_NS), .T_OHZ_NS(T_OHZ_NS), .T_CHZ_NS(T_CHZ_NS)
  ) uSeq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqReady(reqReady), .strobes(strobes)
  );

  sram_ctrl_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uPath (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .sramDin(sramDin),
    .rdData(rdData), .rdValid(rdValid), .sramAddr(sramAddr),
    .sramDout(sramDout), .sramDoutEn(sramDoutEn),
    .sramCeN(sramCeN), .sramWeN(sramWeN), .sramOeN(sramOeN)
  );

endmodule

// File: rtl/sram_async_ctrl_checker.sv
`timescale 1ns/1ps
module sram_async_ctrl_checker
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int CLK_PERIOD_NS = 5,
  parameter int T_OHZ_NS = 20,
  parameter int T_CHZ_NS = 20
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic              rdValid,
  input logic [ADDR_W-1:0] sramAddr,
  input logic              sramDoutEn,
  input logic              sramCeN,
  input logic              sramWeN,
  input logic              sramOeN
);

  localparam int HZ_NEED = maxOf(nsToCycles(T_OHZ_NS, CLK_PERIOD_NS),
                                 nsToCycles(T_CHZ_NS, CLK_PERIOD_NS));
  localparam int SINCE_W = $clog2(HZ_NEED + 2);

  // Cycles since the memory last had its outputs enabled, saturating.
  logic [SINCE_W-1:0] sinceRead;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sinceRead <= SINCE_W'(HZ_NEED + 1);
    else if (!sramOeN) sinceRead <= '0;
    else if (sinceRead < SINCE_W'(HZ_NEED + 1)) sinceRead <= sinceRead + 1'b1;
  end

  assert_idle_pins_R1: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (sramCeN && sramWeN && sramOeN && !sramDoutEn));

  assert_addr_moves_high_R2: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sramAddr) |-> (sramCeN && sramWeN && $past(sramCeN) && $past(sramWeN)));

  assert_read_we_high_R3: assert property (@(posedge clk) disable iff (!rstN)
    !sramOeN |-> (sramWeN && !sramCeN));

  assert_rdvalid_pulse_R3: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !rdValid);

  assert_write_oe_high_R4: assert property (@(posedge clk) disable iff (!rstN)
    !sramWeN |-> (sramOeN && !sramCeN));

  assert_drive_in_strobe_R5: assert property (@(posedge clk) disable iff (!rstN)
    sramDoutEn |-> (!sramWeN && !sramCeN && !$past(sramWeN)));

  assert_drive_off_at_end_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sramWeN) |-> !sramDoutEn);

  assert_turnaround_R6: assert property (@(posedge clk) disable iff (!rstN)
    sramDoutEn |-> (sinceRead >= SINCE_W'(HZ_NEED)));

  assert_busy_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(reqReady) |=> !reqReady);

endmodule

bind sram_async_ctrl sram_async_ctrl_checker #(
  .ADDR_W(ADDR_W), .CLK_PERIOD_NS(CLK_PERIOD_NS),
  .T_OHZ_NS(T_OHZ_NS), .T_CHZ_NS(T_CHZ_NS)
) uChecker (
  .clk(clk), .rstN(rstN), .reqReady(reqReady), .rdValid(rdValid),
  .sramAddr(sramAddr), .sramDoutEn(sramDoutEn), .sramCeN(sramCeN),
  .sramWeN(sramWeN), .sramOeN(sramOeN)
);

// File: tb/tb_sram_async_ctrl.sv
`timescale 1ns/1ps
module tb_sram_async_ctrl;

  localparam int PERIOD = 5;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic        reqWrite = 1'b0;
  logic [14:0] reqAddr = '0;
  logic [7:0]  reqWdata = '0;
  logic [7:0]  rdData;
  logic        rdValid;
  logic [14:0] sramAddr;
  logic [7:0]  sramDout;
  logic [7:0]  sramDin;
  logic        sramDoutEn, sramCeN, sramWeN, sramOeN;

  always #2.5 clk = ~clk;

  sram_async_ctrl dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rdData(rdData), .rdValid(rdValid), .sramAddr(sramAddr),
    .sramDout(sramDout), .sramDin(sramDin), .sramDoutEn(sramDoutEn),
    .sramCeN(sramCeN), .sramWeN(sramWeN), .sramOeN(sramOeN)
  );

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  function automatic void check(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endfunction

  // ---------------- memory model ----------------
  logic [7:0] mem [0:32767];
  logic [7:0] shadow [0:32767];
  int readCnt = 0;
  int relCnt = 100;
  int stbLen = 0;
  int drvLen = 0;
  logic [7:0]  lastData = '0;
  logic [14:0] prevAddr = '0;
  logic        prevCe = 1'b1, prevWe = 1'b1;

  initial for (int i = 0; i < 32768; i++) begin mem[i] = '0; shadow[i] = '0; end

  // Valid only after 55 ns of continuous read selection; poison before.
  assign sramDin = (readCnt * PERIOD >= 55) ? mem[sramAddr] : 8'hEE;

  always @(negedge clk) begin
    if (rstN) begin
      bit reading;
      reading = !sramCeN && !sramOeN && sramWeN;
      readCnt = reading ? readCnt + 1 : 0;
      if (reading) relCnt = 0; else if (relCnt < 100) relCnt++;
      if (sramDoutEn && (reading || relCnt < 4))
        check(1'b0, "R6", "controller drives while memory outputs active", relCnt, 4);
      if (sramAddr != prevAddr && !(sramCeN && sramWeN && prevCe && prevWe))
        check(1'b0, "R2", "address moved with a control pin low", int'(sramAddr), int'(prevAddr));
      if (sramDoutEn && (sramCeN || sramWeN))
        check(1'b0, "R5", "drivers on outside strobe", 1, 0);
      if (!sramCeN && !sramWeN) begin
        stbLen++;
        if (!sramOeN) check(1'b0, "R4", "output enable low during store", 0, 1);
        if (sramDoutEn) begin drvLen++; lastData = sramDout; end
        else if (drvLen > 0) check(1'b0, "R5", "drivers dropped inside strobe", 0, 1);
      end else if (stbLen > 0) begin
        check(stbLen * PERIOD >= 50, "R4", "strobe length ns", stbLen * PERIOD, 50);
        check(drvLen * PERIOD >= 25, "R5", "data setup ns", drvLen * PERIOD, 25);
        mem[sramAddr] = lastData;
        stbLen = 0;
        drvLen = 0;
      end
      prevAddr = sramAddr;
      prevCe = sramCeN;
      prevWe = sramWeN;
    end
  end

  // ---------------- scoreboard ----------------
  logic [7:0] expQ[$];
  int readsIssued = 0;
  int readsSeen = 0;
  bit prevRdValid = 1'b0;

  always @(negedge clk) begin
    if (rstN) begin
      if (rdValid) begin
        readsSeen++;
        check(!prevRdValid, "R3", "rdValid longer than one cycle", 2, 1);
        if (expQ.size() == 0) check(1'b0, "R8", "unexpected load result", int'(rdData), -1);
        else begin
          logic [7:0] e;
          e = expQ.pop_front();
          check(rdData == e, "R3", "load data", int'(rdData), int'(e));
        end
      end
      prevRdValid = rdValid;
    end
  end

  // Driver: waitIdle=0 returns right after acceptance, so the next call
  // holds its request high while the controller is busy.
  task automatic doOp(input bit wr, input logic [14:0] a, input logic [7:0] d, input bit waitIdle);
    int busy;
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d;
    while (!reqReady) @(negedge clk);
    @(posedge clk);
    if (wr) shadow[a] = d;
    else begin expQ.push_back(shadow[a]); readsIssued++; end
    @(negedge clk);
    if (waitIdle) begin
      reqValid = 1'b0;
      busy = 0;
      while (!reqReady) begin busy++; @(negedge clk); end
      check(busy >= 11, "R7", "busy cycles", busy, 11);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(sramCeN && sramWeN && sramOeN, "R1", "control pins in reset", {sramCeN, sramWeN, sramOeN}, 7);
    check(!sramDoutEn && reqReady && !rdValid, "R1", "driver/ready in reset", {sramDoutEn, reqReady, rdValid}, 2);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(sramCeN && sramWeN && sramOeN && !sramDoutEn, "R1", "idle pins", {sramCeN, sramWeN, sramOeN, sramDoutEn}, 14);

    // Boundary addresses and patterns.
    doOp(1'b1, 15'h0000, 8'h00, 1'b1);
    doOp(1'b1, 15'h7FFF, 8'hFF, 1'b1);
    doOp(1'b1, 15'h1234, 8'hA5, 1'b1);
    doOp(1'b0, 15'h7FFF, 8'h00, 1'b1);
    doOp(1'b0, 15'h1234, 8'h00, 1'b1);
    // Load then store to same address (R6 turnaround), then read back.
    doOp(1'b0, 15'h0000, 8'h00, 1'b1);
    doOp(1'b1, 15'h0000, 8'h5A, 1'b1);
    doOp(1'b0, 15'h0000, 8'h00, 1'b1);
    repeat (4) @(negedge clk);
    check(sramCeN && sramWeN && sramOeN && !sramDoutEn && reqReady, "R1", "idle after traffic", 0, 0);

    // R8: back-to-back requests held while busy.
    doOp(1'b1, 15'h0100, 8'h11, 1'b0);
    doOp(1'b1, 15'h0101, 8'h22, 1'b0);
    doOp(1'b0, 15'h0100, 8'h00, 1'b0);
    doOp(1'b1, 15'h0100, 8'h33, 1'b0);
    doOp(1'b0, 15'h0101, 8'h00, 1'b0);
    doOp(1'b0, 15'h0100, 8'h00, 1'b1);

    // Mixed traffic over spread addresses.
    for (int i = 0; i < 24; i++) begin
      logic [14:0] a;
      a = 15'((i * 7919) & 15'h7FFF);
      doOp(1'b1, a, 8'((i * 37) ^ 8'h6C), (i % 3) == 0);
    end
    for (int i = 0; i < 24; i++) begin
      logic [14:0] a;
      a = 15'((i * 7919) & 15'h7FFF);
      doOp(1'b0, a, 8'h00, (i % 2) == 0);
      if (i % 5 == 0) doOp(1'b1, a, 8'(i + 8'h80), 1'b0);
    end
    reqValid = 1'b0;
    while (!reqReady || expQ.size() != 0) @(negedge clk);
    repeat (20) @(negedge clk);

    check(readsSeen == readsIssued, "R8", "load results returned", readsSeen, readsIssued);
    check(mem[15'h0100] == 8'h33, "R8", "held store landed", int'(mem[15'h0100]), 8'h33);
    check(mem[15'h7FFF] == 8'hFF, "R5", "stored byte at top address", int'(mem[15'h7FFF]), 8'hFF);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule